// File: doc/BRIEF.md
# Block Error Status Indicator

This block sits behind a radio data decoder and turns its per-block verdicts into two status outputs. For every received block the decoder pulses a strobe and reports two things: whether the block carried errors before correction, and whether the decoder was in block synchronization. The block counts errored blocks over consecutive windows of a fixed number of blocks, 48 by default. When a window closes, it turns the tally into a 2-bit density code that falls into one of four ranges, and it holds that code until the next window closes.

The sync status output has two forms, chosen by a mode input. In level form it is low while the last completed block was synchronized and high otherwise. In pulse form a synchronized block gives a high pulse of a set number of clock cycles that starts at the block strobe, and the output then goes low. An unsynchronized block holds the output high. In both forms the output describes the block that has just ended, because the state is latched at the strobe. A presence output, also registered, carries the inverse of a data-detected input.

Top module: `errstat_top`

## Requirements
- R1: The error tally counts only those `blkStrobe` cycles on which `blkErr` is also high. `blkErr` outside a strobe has no effect. `errCode` changes only in the cycle after the strobe that closes a window of `WINDOW` (48) strobes, and it holds its value at all other times.
- R2: A window with no errored blocks gives `errCode` = 2'b00.
- R3: A window with 1 to `LOW_MAX` (20) errored blocks gives `errCode` = 2'b01.
- R4: A window with `LOW_MAX`+1 to `MID_MAX` (21 to 40) errored blocks gives `errCode` = 2'b10.
- R5: A window with `MID_MAX`+1 to `WINDOW` (41 to 48) errored blocks gives `errCode` = 2'b11. The polarity of the code is fixed.
- R6: The tally is cleared when a window closes, so each window's code depends only on its own blocks.
- R7: With `pulseMode` low, `syncOut` is low from the cycle after a strobe that saw `inSync` high, and high after a strobe that saw it low. Changes of `inSync` between strobes have no effect.
- R8: With `pulseMode` high, a strobe with `inSync` high makes `syncOut` high for exactly `PULSE_CYCLES` (16) cycles, starting in the next cycle. The output then stays low until the next strobe.
- R9: With `pulseMode` high, a strobe with `inSync` low keeps `syncOut` high until the next strobe.
- R10: `noData` equals the inverse of `dataDetect` from the previous cycle: low when data is detected, high when it is not.
- R11: A synchronous reset (`rst` high) clears the tally and restarts the window. It sets `errCode` to 2'b00 and drives `syncOut` and `noData` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| blkStrobe | input | 1 | One-cycle pulse per decoded block |
| blkErr | input | 1 | Block had errors before correction (valid with strobe) |
| inSync | input | 1 | Decoder is block-synchronized (sampled with strobe) |
| pulseMode | input | 1 | 0: level sync output, 1: timed pulse sync output |
| dataDetect | input | 1 | Data presence detected by the decoder |
| errCode | output | 2 | Error density code of the last closed window |
| syncOut | output | 1 | Sync status of the previous block |
| noData | output | 1 | High when no data is detected |

## Verification
The bound assertions check on every cycle that the code holds between strobes, that a strobe without sync leaves the sync output high, that a synchronized strobe drives the output low in level form and high in pulse form, and that the presence output tracks its input with one cycle of delay. Only the bench scenarios can show the exact band boundaries (0, 1, 20, 21, 40, 41, 48 errors), the clearing of the tally between windows, the exact width of the sync pulse, and the restart of a window after a reset in mid-window.

// File: rtl/errstat_pkg.sv
package errstat_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic blkTick;   // a block result is present this cycle
    logic winClose;  // this block closes the current window
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    BAND_NONE = 2'b00,
    BAND_LOW  = 2'b01,
    BAND_MID  = 2'b10,
    BAND_HIGH = 2'b11
  } errBand_e;

  function automatic errBand_e bandOf(input int unsigned cnt,
                                      input int unsigned lowMax,
                                      input int unsigned midMax);
    if (cnt == 0)           return BAND_NONE;
    else if (cnt <= lowMax) return BAND_LOW;
    else if (cnt <= midMax) return BAND_MID;
    else                    return BAND_HIGH;
  endfunction

endpackage

// File: rtl/errstat_ctrl.sv
module errstat_ctrl
  import errstat_pkg::*;
#(
  parameter int WINDOW = 48
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       blkStrobe,
  output ctlStrobe_t ctl
);
  localparam int IDX_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WINDOW - 1);

  logic [IDX_W-1:0] blkIdx;
  logic             lastOfWin;

  assign lastOfWin = (blkIdx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      blkIdx <= '0;
    end else if (blkStrobe) begin
      if (lastOfWin) blkIdx <= '0;
      else           blkIdx <= blkIdx + 1'b1;
    end
  end

  always_comb begin
    ctl.blkTick  = blkStrobe;
    ctl.winClose = blkStrobe && lastOfWin;
  end

endmodule

// File: rtl/errstat_dp.sv
module errstat_dp
  import errstat_pkg::*;
#(
  parameter int WINDOW  = 48,
  parameter int LOW_MAX = 20,
  parameter int MID_MAX = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  ctlStrobe_t ctl,
  input  logic       blkErr,
  output logic [1:0] errCode
);
  localparam int CNT_W = $clog2(WINDOW + 1);

  logic [CNT_W-1:0] errCnt;
  logic [CNT_W-1:0] errNext;
  errBand_e         codeQ;

  assign errNext = errCnt + CNT_W'(blkErr);

  always_ff @(posedge clk) begin
    if (rst) begin
      errCnt <= '0;
      codeQ  <= BAND_NONE;
    end else if (ctl.winClose) begin
      codeQ  <= bandOf(int'(errNext), LOW_MAX, MID_MAX);
      errCnt <= '0;
    end else if (ctl.blkTick) begin
      errCnt <= errNext;
    end
  end

  assign errCode = codeQ;

endmodule

// File: rtl/errstat_sync.sv
module errstat_sync
  import errstat_pkg::*;
#(
  parameter int PULSE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  ctlStrobe_t ctl,
  input  logic       inSync,
  input  logic       pulseMode,
  input  logic       dataDetect,
  output logic       syncOut,
  output logic       noData
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_CYCLES);

  logic          prevSync;
  logic [PW-1:0] pulseCnt;
  logic          pulseOn;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevSync <= 1'b0;
      pulseCnt <= '0;
    end else if (ctl.blkTick) begin
      prevSync <= inSync;
      pulseCnt <= inSync ? PULSE_LOAD : '0;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign pulseOn = (pulseCnt != '0);
  assign syncOut = pulseMode ? (!prevSync || pulseOn) : !prevSync;

  always_ff @(posedge clk) begin
    if (rst) noData <= 1'b1;
    else     noData <= !dataDetect;
  end

endmodule

// File: rtl/errstat_top.sv
module errstat_top
  import errstat_pkg::*;
#(
  parameter int WINDOW       = 48,
  parameter int LOW_MAX      = 20,
  parameter int MID_MAX      = 40,
  parameter int PULSE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       blkStrobe,
  input  logic       blkErr,
  input  logic       inSync,
  input  logic       pulseMode,
  input  logic       dataDetect,
  output logic [1:0] errCode,
  output logic       syncOut,
  output logic       noData
);
  ctlStrobe_t ctl;

  errstat_ctrl #(.WINDOW(WINDOW)) u_ctrl (
    .clk(clk), .rst(rst), .blkStrobe(blkStrobe), .ctl(ctl)
  );

  errstat_dp #(.WINDOW(WINDOW), .LOW_MAX(LOW_MAX), .MID_MAX(MID_MAX)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .blkErr(blkErr), .errCode(errCode)
  );

  errstat_sync #(.PULSE_CYCLES(PULSE_CYCLES)) u_sync (
    .clk(clk), .rst(rst), .ctl(ctl), .inSync(inSync), .pulseMode(pulseMode),
    .dataDetect(dataDetect), .syncOut(syncOut), .noData(noData)
  );

endmodule

// File: rtl/errstat_chk.sv
module errstat_chk (
  input logic       clk,
  input logic       rst,
  input logic       blkStrobe,
  input logic       blkErr,
  input logic       inSync,
  input logic       pulseMode,
  input logic       dataDetect,
  input logic [1:0] errCode,
  input logic       syncOut,
  input logic       noData
);
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !blkStrobe |=> $stable(errCode)); // R1

  AST_LEVEL_SYNCED: assert property (@(posedge clk) disable iff (rst)
    (blkStrobe && inSync && !pulseMode) |=> (pulseMode || !syncOut)); // R7

  AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
    (blkStrobe && inSync && pulseMode) |=> (syncOut || !pulseMode)); // R8

  AST_UNSYNC_HIGH: assert property (@(posedge clk) disable iff (rst)
    (blkStrobe && !inSync) |=> syncOut); // R9

  AST_PRESENCE_INV: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (noData == !$past(dataDetect))); // R10

  AST_CODE_KNOWN: assert property (@(posedge clk) disable iff (rst)
    blkStrobe |=> !$isunknown(errCode)); // R1

endmodule

bind errstat_top errstat_chk u_chk (.*);

// File: tb/tb_errstat_top.sv
module tb_errstat_top;
  localparam int WIN   = 48;
  localparam int PULSE = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, blkStrobe = 1'b0, blkErr = 1'b0, inSync = 1'b0;
  logic pulseMode = 1'b0, dataDetect = 1'b0;
  logic [1:0] errCode;
  logic syncOut, noData;

  errstat_top dut (.*);

  int nChk = 0, nFail = 0;
  bit done = 0;
  logic lastDetect = 1'b0;
  logic [1:0] prevCode = 2'b00;

  function automatic logic [1:0] expBand(int n);
    if (n == 0) return 2'b00;
    else if (n <= 20) return 2'b01;
    else if (n <= 40) return 2'b10;
    else return 2'b11;
  endfunction

  function automatic string bandTag(int n);
    if (n == 0) return "R2";
    else if (n <= 20) return "R3";
    else if (n <= 40) return "R4";
    else return "R5";
  endfunction

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called just after a negedge; drives one block and checks the gap after it.
  task automatic doBlock(bit err, bit sync, bit closing, logic [1:0] expCode,
                         string codeTag, int gap);
    blkStrobe = 1'b1; blkErr = err; inSync = sync;
    dataDetect = 1'($urandom % 2); lastDetect = dataDetect;
    for (int j = 1; j <= gap; j++) begin
      @(negedge clk);
      if (j == 1) begin
        if (closing) begin
          chk(codeTag, errCode, expCode);
          prevCode = expCode;
        end else begin
          chk("R1 hold", errCode, prevCode);
        end
      end
      if (pulseMode) begin
        if (sync) chk("R8 pulse", syncOut, (j <= PULSE) ? 1 : 0);
        else      chk("R9 unsync", syncOut, 1);
      end else begin
        chk("R7 level", syncOut, sync ? 0 : 1);
      end
      chk("R10 presence", noData, !lastDetect);
      blkStrobe = 1'b0;
      blkErr = 1'($urandom % 2);   // noise outside strobe: ignored (R1)
      inSync = 1'($urandom % 2);   // noise between strobes: ignored (R7)
      dataDetect = 1'($urandom % 2); lastDetect = dataDetect;
    end
  endtask

  task automatic doWindow(int nErr, string tag);
    int remaining = nErr;
    for (int i = 0; i < WIN; i++) begin
      bit e = (remaining > 0) && (($urandom % (WIN - i)) < remaining);
      if (e) remaining--;
      doBlock(e, 1'($urandom % 2), i == WIN - 1, expBand(nErr), tag,
              PULSE + 1 + int'($urandom % 5));
    end
  endtask

  task automatic doReset();
    rst = 1'b1; blkStrobe = 1'b0; dataDetect = 1'b0; lastDetect = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 code", errCode, 0);
    chk("R11 sync", syncOut, 1);
    chk("R11 presence", noData, 1);
    rst = 1'b0;
    prevCode = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int dirCnt[8] = '{0, 1, 20, 21, 40, 41, 48, 0};
    void'($urandom(32'd1234));
    @(negedge clk);
    doReset();

    // Directed sync transitions in both forms (R7, R8, R9)
    for (int m = 0; m < 2; m++) begin
      pulseMode = 1'(m);
      doBlock(0, 1, 0, 2'b00, "R1", PULSE + 3);
      doBlock(0, 1, 0, 2'b00, "R1", PULSE + 3);
      doBlock(0, 0, 0, 2'b00, "R1", PULSE + 3);
      doBlock(0, 1, 0, 2'b00, "R1", PULSE + 3);
      doBlock(0, 0, 0, 2'b00, "R1", PULSE + 3);
      doBlock(0, 0, 0, 2'b00, "R1", PULSE + 3);
    end
    doReset();

    // Directed band boundaries; 48 then 0 shows clearing (R6)
    for (int w = 0; w < 8; w++) begin
      pulseMode = 1'(w % 2);
      doWindow(dirCnt[w], (w == 7) ? "R6 cleared" : bandTag(dirCnt[w]));
    end

    // Mid-window reset restarts the window (R11)
    for (int k = 0; k < 10; k++) doBlock(1, 1, 0, 2'b00, "R1", PULSE + 2);
    doReset();
    pulseMode = 1'b0;
    doWindow(41, "R11 restart R5");

    // Random windows
    for (int r = 0; r < 4; r++) begin
      int n = int'($urandom % (WIN + 1));
      pulseMode = 1'($urandom % 2);
      doWindow(n, bandTag(n));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule